// File: doc/BRIEF.md
# Relocating Partial Configuration Streamer

This block replays a configuration bitstream held in a local buffer bank onto the configuration write bus of a reconfigurable fabric. Each entry of the bitstream is an address word followed by a data word. As each entry goes out, the block replaces the low region field of the address with a region number supplied when the transfer is launched. The same stored bitstream can therefore be placed into any partial region of the fabric, and software does not have to rewrite it first.

Software or a sequencer sets a region number, a buffer base address and a word count, then pulses start. The block reads the buffer as a continuous stream. It keeps one read in flight per cycle and holds the entries in a small queue, so a write can leave on every cycle while the fabric accepts. When the fabric stalls, the entries wait in the queue. Done pulses once after the final entry has been accepted. Instances share no state, so up to sixteen of them can run side by side, and each one is started and finished on its own.

Top module: `reloc_cfg_streamer`

## Requirements
- R1: After reset, busy, done, err, cfg_valid and mem_rd_en are all low.
- R2: Each emitted entry has cfg_addr equal to the stored address word with bits [7:0] replaced by the region number latched at start. Bits [31:8] of cfg_addr and all 32 bits of cfg_data equal the stored words unchanged.
- R3: For a word count W, exactly W/2 entries are emitted. Entry k is built from the words at base+2k (address) and base+2k+1 (data). Entries leave in increasing k, with none lost and none repeated.
- R4: A read is requested by asserting mem_rd_en with mem_rd_addr. The memory returns mem_rd_data one cycle later, with the word at mem_rd_addr in bits [31:0] and the word at mem_rd_addr+1 in bits [63:32]. Successive read addresses step by 2 from base.
- R5: With cfg_ready held high, done is high in the cycle that begins W/2+3 clock edges after the edge that samples start.
- R6: While cfg_valid is high and cfg_ready is low, cfg_valid stays high and cfg_addr and cfg_data hold their values in the following cycle.
- R7: done is high for exactly one cycle, in the cycle after the last entry is accepted. busy is high from the cycle after a valid start through the cycle of that last acceptance, and it is low while done is high.
- R8: A start with a zero or odd word count sets err high, leaves busy low, and issues no reads and no writes. err stays high until the next start with a valid count clears it.
- R9: A start while busy is ignored. The region, base and count of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, sampled on the clock edge |
| region | input | 8 | Target region number substituted into address bits [7:0] |
| base | input | 10 | Buffer word address of the first stored word |
| words | input | 16 | Number of stored words (two per entry) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start request had an invalid count |
| mem_rd_en | output | 1 | Buffer read request |
| mem_rd_addr | output | 10 | Buffer read word address (even word of a pair) |
| mem_rd_data | input | 64 | Buffer read data, one cycle after request |
| cfg_valid | output | 1 | Configuration write valid |
| cfg_ready | input | 1 | Configuration write accepted by the fabric |
| cfg_addr | output | 32 | Relocated configuration address |
| cfg_data | output | 32 | Configuration data |

## Verification
The assertions check five things on every cycle: address bits [7:0] of every valid output equal the latched region; output data is held across a stall; the queue never overflows and read credit is never exceeded; reads and error flags occur only in the states that allow them; and done follows an acceptance. Other behaviour appears only over a whole transfer, so only the bench's scenarios can show it: entries arrive in order with none lost or doubled under irregular ready patterns, the upper address bits and the data match the stored words, the full-rate latency is exact, and a start while busy is ignored.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  localparam int DEF_CFG_W    = 32;
  localparam int DEF_REGION_W = 8;
  localparam int DEF_MEM_AW   = 10;
  localparam int DEF_CNT_W    = 16;
  localparam int DEF_DEPTH    = 4;

  typedef enum logic [1:0] {
    CNT_OK   = 2'd0,
    CNT_ZERO = 2'd1,
    CNT_ODD  = 2'd2
  } cnt_check_e;

  function automatic cnt_check_e classify_count(input logic [DEF_CNT_W-1:0] w);
    if (w == '0)      return CNT_ZERO;
    else if (w[0])    return CNT_ODD;
    else              return CNT_OK;
  endfunction
endpackage

// File: rtl/reloc_ctrl.sv
module reloc_ctrl
  import reloc_pkg::*;
#(
  parameter int REGION_W = DEF_REGION_W,
  parameter int MEM_AW   = DEF_MEM_AW,
  parameter int CNT_W    = DEF_CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [REGION_W-1:0] region_in,
  input  logic [MEM_AW-1:0]   base_in,
  input  logic [CNT_W-1:0]    words_in,
  input  logic                accept,
  output logic                go,
  output logic [CNT_W-1:0]    go_entries,
  output logic [REGION_W-1:0] region_q,
  output logic                busy,
  output logic                done,
  output logic                err
);
  logic [CNT_W-1:0] acc_left;
  logic             cnt_ok;

  assign cnt_ok     = (words_in != '0) && !words_in[0];
  assign go         = start && !busy && cnt_ok;
  assign go_entries = words_in >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      acc_left <= '0;
      region_q <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        if (cnt_ok) begin
          busy     <= 1'b1;
          err      <= 1'b0;
          acc_left <= go_entries;
          region_q <= region_in;
        end else begin
          err <= 1'b1;
        end
      end else if (busy && accept) begin
        acc_left <= acc_left - 1'b1;
        if (acc_left == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R7: done follows an acceptance and never overlaps busy
  assert_done_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(accept) && !busy));
  // R8: error flag never coexists with a running transfer
  assert_err_idle_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);
  // R9: start while busy leaves the latched region alone
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(region_q));
  // R7: no acceptance counted while idle
  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
    accept |-> busy);
endmodule

// File: rtl/reloc_fetch.sv
module reloc_fetch
  import reloc_pkg::*;
#(
  parameter int MEM_AW = DEF_MEM_AW,
  parameter int CNT_W  = DEF_CNT_W,
  parameter int DEPTH  = DEF_DEPTH
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [MEM_AW-1:0]          load_base,
  input  logic [CNT_W-1:0]           load_entries,
  input  logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input  logic                       pop,
  output logic                       rd_en,
  output logic [MEM_AW-1:0]          rd_addr,
  output logic                       rd_valid
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = CW + 2;

  logic [CNT_W-1:0]  rd_left;
  logic [MEM_AW-1:0] next_addr;
  logic [SW-1:0]     used;
  logic [SW-1:0]     limit;
  logic              issue;

  assign used  = SW'(fifo_count) + SW'(rd_en) + SW'(rd_valid);
  assign limit = SW'(DEPTH) + SW'(pop);
  assign issue = (rd_left != '0) && (used < limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en     <= 1'b0;
      rd_valid  <= 1'b0;
      rd_addr   <= '0;
      rd_left   <= '0;
      next_addr <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_en    <= issue;
      if (load) begin
        rd_left   <= load_entries;
        next_addr <= load_base;
      end else if (issue) begin
        rd_left   <= rd_left - 1'b1;
        rd_addr   <= next_addr;
        next_addr <= next_addr + MEM_AW'(2);
      end
    end
  end

  // R6: stored plus in-flight entries never exceed queue depth
  assert_credit_bound_R6: assert property (@(posedge clk) disable iff (rst)
    used <= SW'(DEPTH));
  // R4: read addresses advance by two between consecutive issues
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en) && !$past(load, 2)) |-> (rd_addr == $past(rd_addr) + MEM_AW'(2)));
endmodule

// File: rtl/reloc_rewrite.sv
module reloc_rewrite #(
  parameter int CFG_W    = 32,
  parameter int REGION_W = 8
) (
  input  logic [2*CFG_W-1:0]  pair,
  input  logic [REGION_W-1:0] region,
  output logic [CFG_W-1:0]    out_addr,
  output logic [CFG_W-1:0]    out_data
);
  always_comb begin
    out_addr = {pair[CFG_W-1:REGION_W], region};
    out_data = pair[2*CFG_W-1:CFG_W];
  end
endmodule

// File: rtl/reloc_fifo.sv
module reloc_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [WIDTH-1:0]           din,
  input  logic                       pop,
  output logic [WIDTH-1:0]           dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       nonempty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout     = store[rd_ptr];
  assign nonempty = (count != '0);

  // R6: queue never overflows or underflows
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (count < CW'(DEPTH)));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/reloc_cfg_streamer.sv
module reloc_cfg_streamer
  import reloc_pkg::*;
#(
  parameter int CFG_W    = DEF_CFG_W,
  parameter int REGION_W = DEF_REGION_W,
  parameter int MEM_AW   = DEF_MEM_AW,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int DEPTH    = DEF_DEPTH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [REGION_W-1:0] region,
  input  logic [MEM_AW-1:0]   base,
  input  logic [CNT_W-1:0]    words,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                mem_rd_en,
  output logic [MEM_AW-1:0]   mem_rd_addr,
  input  logic [2*CFG_W-1:0]  mem_rd_data,
  output logic                cfg_valid,
  input  logic                cfg_ready,
  output logic [CFG_W-1:0]    cfg_addr,
  output logic [CFG_W-1:0]    cfg_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic                go;
  logic [CNT_W-1:0]    go_entries;
  logic [REGION_W-1:0] region_q;
  logic                pop;
  logic                rd_valid;
  logic [CW-1:0]       fifo_count;
  logic [CFG_W-1:0]    rw_addr;
  logic [CFG_W-1:0]    rw_data;
  logic [2*CFG_W-1:0]  head;

  assign pop = cfg_valid && cfg_ready;

  reloc_ctrl #(.REGION_W(REGION_W), .MEM_AW(MEM_AW), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .region_in(region), .base_in(base),
    .words_in(words), .accept(pop), .go(go), .go_entries(go_entries),
    .region_q(region_q), .busy(busy), .done(done), .err(err)
  );

  reloc_fetch #(.MEM_AW(MEM_AW), .CNT_W(CNT_W), .DEPTH(DEPTH)) fetch_i (
    .clk(clk), .rst(rst), .load(go), .load_base(base), .load_entries(go_entries),
    .fifo_count(fifo_count), .pop(pop), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
    .rd_valid(rd_valid)
  );

  reloc_rewrite #(.CFG_W(CFG_W), .REGION_W(REGION_W)) rewrite_i (
    .pair(mem_rd_data), .region(region_q), .out_addr(rw_addr), .out_data(rw_data)
  );

  reloc_fifo #(.WIDTH(2*CFG_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(rd_valid), .din({rw_addr, rw_data}), .pop(pop),
    .dout(head), .count(fifo_count), .nonempty(cfg_valid)
  );

  assign cfg_addr = head[2*CFG_W-1:CFG_W];
  assign cfg_data = head[CFG_W-1:0];

  // R2: every offered write targets the latched region
  assert_region_field_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (cfg_addr[REGION_W-1:0] == region_q));
  // R6: stalled output is held
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_addr) && $stable(cfg_data)));
  // R4 / R8: reads only during a transfer
  assert_read_when_busy_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);
  // R8: no write offered while idle
  assert_valid_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> busy);
endmodule

// File: tb/reloc_cfg_streamer_tb_top.sv
module reloc_cfg_streamer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [7:0]  region;
  logic [9:0]  base;
  logic [15:0] words;
  logic        busy, done, err;
  logic        mem_rd_en;
  logic [9:0]  mem_rd_addr;
  logic [63:0] mem_rd_data;
  logic        cfg_valid, cfg_ready;
  logic [31:0] cfg_addr, cfg_data;

  int checks = 0;
  int errors = 0;
  int edges  = 0;

  always #4 clk = ~clk;

  reloc_cfg_streamer dut_i (
    .clk(clk), .rst(rst), .start(start), .region(region), .base(base), .words(words),
    .busy(busy), .done(done), .err(err), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  function automatic logic [31:0] word_at(input logic [9:0] i);
    return {6'h2B, i, i[7:0] ^ 8'h5A, ~i[7:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= {word_at(mem_rd_addr + 10'd1), word_at(mem_rd_addr)};
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    edges++;
    if (edges > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // region[39:32] base[31:16] words[15:8] ready pattern[7:0]
  localparam logic [39:0] SCEN [6] = '{
    {8'h05, 16'd0,    8'd8,  8'hFF},
    {8'hF0, 16'd100,  8'd16, 8'hAA},
    {8'h00, 16'd1000, 8'd20, 8'h3C},
    {8'hFF, 16'd7,    8'd2,  8'h01},
    {8'h80, 16'd512,  8'd40, 8'hEE},
    {8'h3A, 16'd300,  8'd6,  8'hFF}
  };

  task automatic run_xfer(input logic [7:0] rg, input logic [9:0] bs, input logic [15:0] wc,
                          input logic [7:0] pat, input bit poke);
    int n = int'(wc) / 2;
    int idx = 0;
    int cyc = 0;
    bit fin = 0;
    logic [31:0] ea, ed;
    @(negedge clk);
    start = 1'b1; region = rg; base = bs; words = wc; cfg_ready = 1'b0;
    while (!fin && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (poke && cyc == 3) begin
        start = 1'b1; region = ~rg; base = bs + 10'd64; words = 16'd4;
      end
      cfg_ready = pat[cyc % 8];
      #1;
      if (cyc == 1) begin
        chk(busy === 1'b1, "R7 busy after start", 64'(busy), 64'd1);
        chk(err === 1'b0, "R8 err cleared by valid start", 64'(err), 64'd0);
      end
      if (poke && cyc == 3)
        chk(busy === 1'b1, "R9 busy while poked", 64'(busy), 64'd1);
      if (cfg_valid && cfg_ready) begin
        ea = {word_at(bs + 10'(2*idx))[31:8], rg};
        ed = word_at(bs + 10'(2*idx + 1));
        chk(idx < n && cfg_addr === ea && cfg_data === ed, "R2 R4 R9 entry",
            {cfg_addr, cfg_data}, {ea, ed});
        idx++;
      end
      if (done) begin
        fin = 1;
        chk(busy === 1'b0, "R7 busy low with done", 64'(busy), 64'd0);
        chk(idx == n, "R3 R6 entry count", 64'(idx), 64'(n));
        if (pat == 8'hFF)
          chk(cyc == n + 4, "R5 full-rate latency", 64'(cyc), 64'(n + 4));
      end
    end
    chk(fin, "R7 done seen", 64'(fin), 64'd1);
    @(negedge clk);
    #1;
    chk(done === 1'b0, "R7 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic bad_start(input logic [15:0] wc);
    bit saw = 0;
    @(negedge clk);
    start = 1'b1; words = wc; region = 8'h11; base = 10'd0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start = 1'b0;
      cfg_ready = 1'b1;
      #1;
      if (mem_rd_en || cfg_valid || busy) saw = 1;
    end
    chk(err === 1'b1, "R8 err on bad count", 64'(err), 64'd1);
    chk(!saw, "R8 no activity on bad count", 64'(saw), 64'd0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; region = '0; base = '0; words = '0; cfg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk({busy, done, err, cfg_valid, mem_rd_en} === 5'b0, "R1 reset state",
        64'({busy, done, err, cfg_valid, mem_rd_en}), 64'd0);

    for (int s = 0; s < 6; s++)
      run_xfer(SCEN[s][39:32], SCEN[s][25:16], {8'd0, SCEN[s][15:8]}, SCEN[s][7:0], 1'b0);

    bad_start(16'd5);
    run_xfer(8'h42, 10'd20, 16'd4, 8'hFF, 1'b0);
    bad_start(16'd0);
    chk(busy === 1'b0, "R8 idle after zero count", 64'(busy), 64'd0);
    run_xfer(8'h9C, 10'd40, 16'd12, 8'hB7, 1'b1);
    run_xfer(8'h01, 10'd1022, 16'd2, 8'hFF, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule